// File: doc/BRIEF.md
# Synchronous Burst SRAM Command Decoder

This block sits in front of a single-cycle, no-wait-state synchronous burst SRAM array. On every rising clock edge it samples the chip-select, load/advance, write-enable, byte-enable, output-enable and clock-enable pins and classifies the cycle. The classes are deselect, continue-deselect, begin read, continue read, dummy read (at load or during a burst), begin write, continue write, write abort (at load or during a burst), and ignored clock. A latched burst class means that an advance cycle repeats the read, write or deselect behaviour that was last loaded.

An internal address register takes the external address on a load cycle. On each advance cycle of a read or write burst it steps its two lowest bits in linear order, wrapping inside an aligned four-word group. The decoded operation, the active address and the per-byte write strobes are registered at the sampling edge. The output-drive enable is the registered read state gated directly by the live, asynchronous output-enable pin. The memory array and any sleep control are outside this block.

Top module: `sramBurstDecoder`

## Requirements
- R1: When clkEnN is high at a rising edge, opCode becomes 10 (ignored clock), byteStrobe becomes zero, and activeAddr and the burst class are held unchanged.
- R2: With clkEnN low and adv low, the cycle is a deselect (opCode 0) if ceN is high, or ce2 is low, or ce3N is high. The burst class returns to deselect and activeAddr is held.
- R3: With clkEnN and adv low, all chip selects active (ceN low, ce2 high, ce3N low) and weN high, activeAddr loads extAddr and the read class is entered. opCode is 2 (begin read) when oeN is low and 4 (load-time dummy read) when oeN is high.
- R4: With clkEnN and adv low, all chip selects active and weN low, activeAddr loads extAddr and the write class is entered. opCode is 6 (begin write) if any byteWeN bit is low and 8 (load-time write abort) if every byteWeN bit is high.
- R5: With clkEnN low and adv high, the chip selects and weN are ignored. In the read class opCode is 3 (continue read) with oeN low and 5 (burst dummy read) with oeN high. In the write class it is 7 (continue write) if any byteWeN bit is low and 9 (burst write abort) otherwise. In the deselect class it is 1 (continue deselect), so continue-deselect is only reached after a deselect.
- R6: Each advance cycle in the read or write class steps activeAddr[1:0] by one modulo 4 and keeps the upper bits from the load cycle. Deselect, continue-deselect and ignored cycles do not move activeAddr.
- R7: byteStrobe bit i is high after a cycle only if that cycle was a begin write or continue write and byteWeN bit i was low in it; otherwise all bits are low.
- R8: driveEn is high only while the burst class is read and the live oeN pin is low; a change on oeN reaches driveEn without a clock edge.
- R9: With rst high at a rising edge, the class becomes deselect, opCode 0, activeAddr 0, byteStrobe 0 and driveEn 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clkEnN | input | 1 | Clock enable, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new command |
| ceN | input | 1 | First chip select, active low |
| ce2 | input | 1 | Second chip select, active high |
| ce3N | input | 1 | Third chip select, active low |
| weN | input | 1 | Write enable, active low |
| byteWeN | input | BYTES | Per-byte write enables, active low |
| oeN | input | 1 | Output enable, active low, asynchronous |
| extAddr | input | ADDR_W | External address loaded on begin cycles |
| opCode | output | 4 | Decoded operation of the last sampled cycle |
| activeAddr | output | ADDR_W | Address used by the last sampled cycle |
| byteStrobe | output | BYTES | Per-byte write strobes, active high |
| driveEn | output | 1 | Read data output-drive enable |

## Verification
The bench targets the burst wrap at the top of a four-word group. A counter that carries into bit 2 would walk out of the aligned group and move the upper address. It checks each of the three chip selects on its own, so a polarity slip on any one pin shows up as a read or write where a deselect was due. It sends advance cycles right after deselects, after writes whose byte enables are all high, and across ignored clocks. A decoder that does not latch the burst class, that treats an all-high byte mask as a write, or that advances during a held clock would report the wrong operation or address. It also toggles output enable between edges to catch a drive enable that waits for a clock.

// File: rtl/sramDecPkg.sv
package sramDecPkg;

  typedef enum logic [3:0] {
    OP_DESEL      = 4'd0,
    OP_CONT_DESEL = 4'd1,
    OP_BEGIN_RD   = 4'd2,
    OP_CONT_RD    = 4'd3,
    OP_DUMMY_LD   = 4'd4,
    OP_DUMMY_CONT = 4'd5,
    OP_BEGIN_WR   = 4'd6,
    OP_CONT_WR    = 4'd7,
    OP_ABORT_LD   = 4'd8,
    OP_ABORT_CONT = 4'd9,
    OP_IGNORE     = 4'd10
  } opCodeT;

  typedef enum logic [2:0] {
    ST_DESEL    = 3'd0,
    ST_BEGIN_RD = 3'd1,
    ST_BEGIN_WR = 3'd2,
    ST_BURST_RD = 3'd3,
    ST_BURST_WR = 3'd4
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic stepAddr;
    logic wrEnable;
    logic rdState;
  } ctrlStrbT;

endpackage

// File: rtl/sramDecCtrl.sv
module sramDecCtrl
  import sramDecPkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clkEnN,
  input  logic             adv,
  input  logic             ceN,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             weN,
  input  logic [BYTES-1:0] byteWeN,
  input  logic             oeN,
  output opCodeT           opCode,
  output ctrlStrbT         strb
);

  stateT  curState, nextState;
  opCodeT nextOp;
  logic   chipOff, noBytes;

  assign chipOff = ceN | ~ce2 | ce3N;
  assign noBytes = &byteWeN;

  always_comb begin
    nextState     = curState;
    nextOp        = OP_IGNORE;
    strb.loadAddr = 1'b0;
    strb.stepAddr = 1'b0;
    strb.wrEnable = 1'b0;
    if (!clkEnN) begin
      if (!adv) begin
        if (chipOff) begin
          nextOp    = OP_DESEL;
          nextState = ST_DESEL;
        end else if (weN) begin
          nextOp        = oeN ? OP_DUMMY_LD : OP_BEGIN_RD;
          nextState     = ST_BEGIN_RD;
          strb.loadAddr = 1'b1;
        end else begin
          nextOp        = noBytes ? OP_ABORT_LD : OP_BEGIN_WR;
          nextState     = ST_BEGIN_WR;
          strb.loadAddr = 1'b1;
          strb.wrEnable = ~noBytes;
        end
      end else begin
        unique case (curState)
          ST_BEGIN_RD, ST_BURST_RD: begin
            nextOp        = oeN ? OP_DUMMY_CONT : OP_CONT_RD;
            nextState     = ST_BURST_RD;
            strb.stepAddr = 1'b1;
          end
          ST_BEGIN_WR, ST_BURST_WR: begin
            nextOp        = noBytes ? OP_ABORT_CONT : OP_CONT_WR;
            nextState     = ST_BURST_WR;
            strb.stepAddr = 1'b1;
            strb.wrEnable = ~noBytes;
          end
          default: begin
            nextOp    = OP_CONT_DESEL;
            nextState = ST_DESEL;
          end
        endcase
      end
    end
  end

  assign strb.rdState = (curState == ST_BEGIN_RD) || (curState == ST_BURST_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= ST_DESEL;
      opCode   <= OP_DESEL;
    end else begin
      curState <= nextState;
      opCode   <= nextOp;
    end
  end

endmodule

// File: rtl/sramDecAddr.sv
module sramDecAddr
  import sramDecPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrbT          strb,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [BYTES-1:0]  byteWeN,
  input  logic              oeN,
  output logic [ADDR_W-1:0] activeAddr,
  output logic [BYTES-1:0]  byteStrobe,
  output logic              driveEn
);

  localparam int WRAP_W = 2;

  logic [WRAP_W-1:0] lowNext;

  assign lowNext = activeAddr[WRAP_W-1:0] + WRAP_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      activeAddr <= '0;
      byteStrobe <= '0;
    end else begin
      if (strb.loadAddr) begin
        activeAddr <= extAddr;
      end else if (strb.stepAddr) begin
        activeAddr[WRAP_W-1:0] <= lowNext;
      end
      byteStrobe <= strb.wrEnable ? ~byteWeN : '0;
    end
  end

  // live output enable gates the registered read state
  assign driveEn = strb.rdState & ~oeN;

endmodule

// File: rtl/sramBurstDecoder.sv
module sramBurstDecoder
  import sramDecPkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkEnN,
  input  logic              adv,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic [BYTES-1:0]  byteWeN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [3:0]        opCode,
  output logic [ADDR_W-1:0] activeAddr,
  output logic [BYTES-1:0]  byteStrobe,
  output logic              driveEn
);

  ctrlStrbT strb;
  opCodeT   opEnum;

  sramDecCtrl #(.BYTES(BYTES)) ctrl (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .adv(adv),
    .ceN(ceN), .ce2(ce2), .ce3N(ce3N), .weN(weN),
    .byteWeN(byteWeN), .oeN(oeN), .opCode(opEnum), .strb(strb)
  );

  sramDecAddr #(.ADDR_W(ADDR_W), .BYTES(BYTES)) addrPath (
    .clk(clk), .rst(rst), .strb(strb), .extAddr(extAddr),
    .byteWeN(byteWeN), .oeN(oeN), .activeAddr(activeAddr),
    .byteStrobe(byteStrobe), .driveEn(driveEn)
  );

  assign opCode = opEnum;

endmodule

// File: rtl/sramDecChecker.sv
module sramDecChecker #(
  parameter int ADDR_W = 18,
  parameter int BYTES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clkEnN,
  input logic              adv,
  input logic              ceN,
  input logic              ce2,
  input logic              ce3N,
  input logic              weN,
  input logic [BYTES-1:0]  byteWeN,
  input logic              oeN,
  input logic [ADDR_W-1:0] extAddr,
  input logic [3:0]        opCode,
  input logic [ADDR_W-1:0] activeAddr,
  input logic [BYTES-1:0]  byteStrobe,
  input logic              driveEn
);

  AST_IGNORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    clkEnN |=> (opCode == 4'd10) && $stable(activeAddr) && (byteStrobe == '0)); // R1

  AST_CHIP_OFF_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!clkEnN && !adv && (ceN || !ce2 || ce3N)) |=> (opCode == 4'd0) && $stable(activeAddr)); // R2

  AST_CONT_DESEL_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    (opCode == 4'd1 && $past(opCode) != 4'd10) |-> ($past(opCode) == 4'd0 || $past(opCode) == 4'd1)); // R5

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (opCode == 4'd3 || opCode == 4'd5 || opCode == 4'd7 || opCode == 4'd9) |->
      (activeAddr[ADDR_W-1:2] == $past(activeAddr[ADDR_W-1:2])) &&
      (activeAddr[1:0] == $past(activeAddr[1:0]) + 2'd1)); // R6

  AST_STROBE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (byteStrobe != '0) |-> (opCode == 4'd6 || opCode == 4'd7)); // R7

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    driveEn |-> !oeN); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (opCode == 4'd0) && (activeAddr == '0) && (byteStrobe == '0)); // R9

endmodule

bind sramBurstDecoder sramDecChecker #(.ADDR_W(ADDR_W), .BYTES(BYTES)) chk (.*);

// File: tb/tb_sramBurstDecoder.sv
module tb_sramBurstDecoder;

  localparam int AW = 18;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clkEnN = 1'b0, adv = 1'b0, ceN = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic          weN = 1'b1, oeN = 1'b1;
  logic [BW-1:0] byteWeN = '1;
  logic [AW-1:0] extAddr = '0;
  logic [3:0]    opCode;
  logic [AW-1:0] activeAddr;
  logic [BW-1:0] byteStrobe;
  logic          driveEn;

  int total = 0;
  int bad   = 0;

  // reference model state: class 0 deselect, 1 read, 2 write
  int            mCls = 0;
  int            mOp  = 0;
  logic [AW-1:0] mAddr = '0;
  logic [BW-1:0] mStrb = '0;

  sramBurstDecoder #(.ADDR_W(AW), .BYTES(BW)) dut (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .adv(adv), .ceN(ceN), .ce2(ce2),
    .ce3N(ce3N), .weN(weN), .byteWeN(byteWeN), .oeN(oeN), .extAddr(extAddr),
    .opCode(opCode), .activeAddr(activeAddr), .byteStrobe(byteStrobe), .driveEn(driveEn)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    if (rst) begin
      mCls = 0; mOp = 0; mAddr = '0; mStrb = '0;
    end else if (clkEnN) begin
      mOp = 10; mStrb = '0;
    end else if (!adv) begin
      if (ceN || !ce2 || ce3N) begin
        mOp = 0; mCls = 0; mStrb = '0;
      end else if (weN) begin
        mOp = oeN ? 4 : 2; mCls = 1; mAddr = extAddr; mStrb = '0;
      end else begin
        mOp = (byteWeN == '1) ? 8 : 6; mCls = 2; mAddr = extAddr; mStrb = ~byteWeN;
      end
    end else begin
      if (mCls == 0) begin
        mOp = 1; mStrb = '0;
      end else begin
        mAddr = {mAddr[AW-1:2], 2'(mAddr[1:0] + 2'd1)};
        if (mCls == 1) begin
          mOp = oeN ? 5 : 3; mStrb = '0;
        end else begin
          mOp = (byteWeN == '1) ? 9 : 7; mStrb = ~byteWeN;
        end
      end
    end
  endtask

  // one clock: inputs already set, model at the edge, compare at the falling edge
  task automatic cycle(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(tag, "opCode", opCode, mOp);
    chk(tag, "activeAddr", activeAddr, mAddr);
    chk(tag, "byteStrobe", byteStrobe, mStrb);
    chk(tag, "driveEn", driveEn, (mCls == 1) && !oeN);
  endtask

  task automatic load(input logic en, input logic c1, input logic c2, input logic c3,
                      input logic we, input logic [BW-1:0] bw, input logic oe,
                      input logic [AW-1:0] a, input string tag);
    clkEnN = en; adv = 1'b0; ceN = c1; ce2 = c2; ce3N = c3;
    weN = we; byteWeN = bw; oeN = oe; extAddr = a;
    cycle(tag);
  endtask

  task automatic advance(input logic [BW-1:0] bw, input logic oe, input string tag);
    clkEnN = 1'b0; adv = 1'b1; byteWeN = bw; oeN = oe;
    // chip selects and write enable scrambled: must be ignored
    ceN = 1'b1; ce2 = 1'b0; weN = ~weN; extAddr = ~extAddr;
    cycle(tag);
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cycle("R9");
    cycle("R9");
    cycle("R9");
    rst = 1'b0;

    // continue-deselect straight after reset
    advance('1, 1'b0, "R5");
    // each chip select alone turns the part off
    load(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, '1, 1'b0, 18'h00155, "R2");
    load(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, '1, 1'b0, 18'h00155, "R2");
    load(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 1'b0, 18'h00155, "R2");

    // begin read, walk and wrap inside the four-word group
    load(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, 1'b0, 18'h2A103, "R3");
    advance('1, 1'b0, "R6");
    advance('1, 1'b1, "R5");
    advance('1, 1'b0, "R6");
    // held clock keeps state and address
    clkEnN = 1'b1; cycle("R1");
    clkEnN = 1'b1; cycle("R1");
    advance('1, 1'b0, "R6");

    // drive enable follows oeN with no clock
    #1; oeN = 1'b1; #1; chk("R8", "driveEn async off", driveEn, 0);
    oeN = 1'b0; #1; chk("R8", "driveEn async on", driveEn, 1);

    // load-time dummy read
    load(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, 1'b1, 18'h00042, "R3");
    advance('1, 1'b1, "R5");

    // write with mixed byte enables, then abort and full write in burst
    load(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1010, 1'b0, 18'h3FFFE, "R4");
    advance(4'b1111, 1'b0, "R5");
    advance(4'b0000, 1'b0, "R7");
    advance(4'b0110, 1'b1, "R7");
    // load-time write abort
    load(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1111, 1'b0, 18'h01230, "R4");
    advance(4'b1110, 1'b0, "R7");
    // deselect then continue-deselect after a write
    load(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 1'b0, 18'h00000, "R2");
    advance(4'b0000, 1'b0, "R5");
    clkEnN = 1'b1; cycle("R1");
    advance(4'b0000, 1'b0, "R5");

    // mid-run reset
    load(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, 1'b0, 18'h0BEEF, "R3");
    rst = 1'b1; cycle("R9");
    rst = 1'b0;
    advance('1, 1'b0, "R5");

    // randomized traffic against the model
    for (int i = 0; i < 3000; i++) begin
      clkEnN  = ($urandom_range(0, 9) == 0);
      adv     = ($urandom_range(0, 2) != 0);
      ceN     = ($urandom_range(0, 5) == 0);
      ce2     = ($urandom_range(0, 5) != 0);
      ce3N    = ($urandom_range(0, 5) == 0);
      weN     = $urandom_range(0, 1);
      byteWeN = ($urandom_range(0, 3) == 0) ? '1 : BW'($urandom);
      oeN     = ($urandom_range(0, 3) == 0);
      extAddr = AW'($urandom);
      cycle("R5");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule